// File: doc/BRIEF.md
# Vehicle Alarm Arming Sequencer

This block is the control core of a vehicle alarm. A single command bit from the remote receiver arms or disarms it, and a single intrusion bit from the body sensors trips it. Both lines come from outside this clock domain. Each one passes through its own flip-flop synchronizer before any decision is made on it.

One button press usually holds the command line high for many clock cycles. A guard state sits between "off" and "on" in each direction. The machine waits in that guard state until the command line drops, so one press causes exactly one change of mode. The outputs are a Moore decode of the present state. Both outputs are assigned in every state, so the decode is purely combinational and contains no latches.

There are five modes: off, arming guard, on, disarming guard and tripped. The siren sounds only in the tripped mode. Once tripped, the machine stays tripped until a remote press disarms it.

Top module: `alarm_seq`

## Requirements
- R1: While `rst_n` is low, and immediately when it goes low (asynchronously), `armed` and `siren` are 0 and the machine is in the off mode.
- R2: In the off mode, a synchronized `remote_in` of 1 moves the machine to the arming guard, where `armed` = 1 and `siren` = 0.
- R3: While the synchronized `remote_in` stays 1, `armed` and `siren` do not change, however many cycles the press lasts.
- R4: The arming guard goes to the on mode only after the synchronized `remote_in` returns to 0. A new press is needed to disarm.
- R5: In the on mode, a synchronized `remote_in` of 1 moves the machine to the disarming guard (`armed` = 0, `siren` = 0), whatever the value of `sensor_in`.
- R6: In the on mode, a synchronized `sensor_in` of 1 with `remote_in` 0 moves the machine to the tripped mode (`armed` = 1, `siren` = 1).
- R7: The tripped mode holds `siren` = 1 after `sensor_in` returns to 0. Only a synchronized `remote_in` of 1 leaves it, and it leaves to the disarming guard.
- R8: `sensor_in` has no effect in the off mode or in either guard state; `siren` stays 0 there.
- R9: Each input passes through a `SYNC_STAGES`-deep synchronizer (default 2). With the default, an input change appears on the outputs after exactly three rising clock edges, and not earlier.
- R10: `siren` = 1 is never seen with `armed` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| remote_in | input | 1 | Remote arm/disarm command, asynchronous |
| sensor_in | input | 1 | Intrusion sensor, asynchronous |
| armed | output | 1 | High while arming, armed or tripped |
| siren | output | 1 | Siren enable, high only when tripped |

## Verification
A wrong internal state shows up on `armed` or `siren` no later than the third rising edge after the input that caused it. The outputs decode the state with no extra register in between.

The two guard states share an output pattern with other modes: the arming guard looks like the on mode, and the disarming guard looks like the off mode. A machine that skips a guard is therefore exposed by what happens next. It either toggles during a long press, or it accepts a release or a sensor event that it should have ignored. The stimulus is built to provoke exactly those follow-on effects.

// File: rtl/alarm_seq.sv
module alarm_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic remote_in,
  input  logic sensor_in,
  output logic armed,
  output logic siren
);
  localparam int TOP = SYNC_STAGES - 1;

  typedef enum logic [2:0] {
    OFF      = 3'd0,
    ARM_HOLD = 3'd1,
    ON       = 3'd2,
    DIS_HOLD = 3'd3,
    TRIPPED  = 3'd4
  } mode_t;

  mode_t mode, mode_nx;
  logic [TOP:0] rem_q, sen_q;
  logic remote_s, sensor_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rem_q <= '0;
      sen_q <= '0;
    end else begin
      rem_q <= {rem_q[TOP-1:0], remote_in};
      sen_q <= {sen_q[TOP-1:0], sensor_in};
    end

  assign remote_s = rem_q[TOP];
  assign sensor_s = sen_q[TOP];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= OFF;
    else        mode <= mode_nx;

  always_comb begin
    mode_nx = mode;
    case (mode)
      OFF:      if (remote_s)      mode_nx = ARM_HOLD;
      ARM_HOLD: if (!remote_s)     mode_nx = ON;
      ON:       if (remote_s)      mode_nx = DIS_HOLD;
                else if (sensor_s) mode_nx = TRIPPED;
      TRIPPED:  if (remote_s)      mode_nx = DIS_HOLD;
      DIS_HOLD: if (!remote_s)     mode_nx = OFF;
      default:                     mode_nx = OFF;
    endcase
  end

  always_comb begin
    armed = 1'b0;
    siren = 1'b0;
    case (mode)
      OFF:      begin armed = 1'b0; siren = 1'b0; end
      ARM_HOLD: begin armed = 1'b1; siren = 1'b0; end
      ON:       begin armed = 1'b1; siren = 1'b0; end
      DIS_HOLD: begin armed = 1'b0; siren = 1'b0; end
      TRIPPED:  begin armed = 1'b1; siren = 1'b1; end
      default:  begin armed = 1'b0; siren = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alarm_seq_chk.sv
module alarm_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic remote_s,
  input logic sensor_s,
  input logic armed,
  input logic siren
);
  always @(negedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!armed && !siren); // R1

  AST_ARM_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(remote_s)); // R2

  AST_HELD_PRESS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_s && $past(remote_s)) |=> ($stable(armed) && $stable(siren))); // R3

  AST_DISARM_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(remote_s)); // R5

  AST_TRIP_FROM_SENSOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(siren) |-> ($past(sensor_s) && !$past(remote_s) && $past(armed))); // R6

  AST_TRIP_CLEARED_BY_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(siren) |-> $past(remote_s)); // R7

  AST_SIREN_IMPLIES_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    siren |-> armed); // R10
endmodule

bind alarm_seq alarm_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .remote_s (remote_s),
  .sensor_s (sensor_s),
  .armed    (armed),
  .siren    (siren)
);

// File: tb/alarm_seq_test.sv
module alarm_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remote_in = 1'b0;
  logic sensor_in = 1'b0;
  logic armed, siren;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alarm_seq uut (
    .clk(clk), .rst_n(rst_n), .remote_in(remote_in), .sensor_in(sensor_in),
    .armed(armed), .siren(siren)
  );

  // {remote, sensor, expected armed, expected siren}
  localparam logic [3:0] VEC [14] = '{
    4'b0100, // R8 sensor while off
    4'b1010, // R2 press -> arming guard
    4'b1110, // R8 sensor in arming guard, R3 still held
    4'b1010, // R3
    4'b0010, // R4 release -> on
    4'b0111, // R6 trip
    4'b0011, // R7 siren held
    4'b1000, // R7 remote clears
    4'b1100, // R8 sensor in disarming guard
    4'b0100, // R8 back off, sensor ignored
    4'b1010, // R2
    4'b0010, // R4
    4'b1100, // R5 disarm with sensor high
    4'b0000  // R5 off
  };

  function automatic string row_req(int i);
    case (i)
      0, 2, 8, 9: return "R8";
      1, 10:      return "R2";
      3:          return "R3";
      4, 11:      return "R4";
      5:          return "R6";
      6, 7:       return "R7";
      default:    return "R5";
    endcase
  endfunction

  task automatic check(string req, logic a, logic s, logic ea, logic es);
    compared++;
    if (a !== ea || s !== es) begin
      mismatched++;
      $display("FAIL %s: armed=%b siren=%b expected armed=%b siren=%b", req, a, s, ea, es);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    check("R1", armed, siren, 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    check("R1", armed, siren, 1'b0, 1'b0);

    for (int i = 0; i < 14; i++) begin
      remote_in = VEC[i][3];
      sensor_in = VEC[i][2];
      cyc(6);
      check(row_req(i), armed, siren, VEC[i][1], VEC[i][0]);
      check("R10", 1'b0, siren & ~armed, 1'b0, 1'b0);
    end

    remote_in = 1'b1;
    cyc(1); check("R9", armed, siren, 1'b0, 1'b0);
    cyc(1); check("R9", armed, siren, 1'b0, 1'b0);
    cyc(1); check("R9", armed, siren, 1'b1, 1'b0);
    for (int k = 0; k < 100; k++) begin
      cyc(1);
      check("R3", armed, siren, 1'b1, 1'b0);
    end
    remote_in = 1'b0;
    cyc(6);
    check("R4", armed, siren, 1'b1, 1'b0);
    remote_in = 1'b1;
    cyc(3);
    check("R5", armed, siren, 1'b0, 1'b0);
    for (int k = 0; k < 60; k++) begin
      cyc(1);
      check("R3", armed, siren, 1'b0, 1'b0);
    end
    remote_in = 1'b0;
    cyc(6);
    check("R4", armed, siren, 1'b0, 1'b0);

    remote_in = 1'b1; cyc(6);
    remote_in = 1'b0; cyc(6);
    sensor_in = 1'b1;
    cyc(2); check("R9", armed, siren, 1'b1, 1'b0);
    cyc(1); check("R6", armed, siren, 1'b1, 1'b1);
    sensor_in = 1'b0;
    cyc(20);
    check("R7", armed, siren, 1'b1, 1'b1);

    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 check("R1", armed, siren, 1'b0, 1'b0);
    cyc(2);
    check("R1", armed, siren, 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(6);
    check("R1", armed, siren, 1'b0, 1'b0);

    done = 1'b1;
  end

  initial begin
    int ticks = 0;
    while (!done && ticks < 5000) begin
      @(posedge clk);
      ticks++;
    end
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule